// File: doc/BRIEF.md
# Supply-Loss Write Guard and Backup Switch Sequencer

This block watches the health of the supply that feeds a battery-backed static memory and decides, cycle by cycle, whether the memory may be accessed. Three digital comparator flags arrive asynchronously. The first says the supply is inside the operating window. The second says it has fallen past the level where writes must stop. The third says it has fallen past the level where the array must run from the backup cell. The block resynchronises these flags and runs a five-state sequencer on them.

From that sequencer it drives the memory-side chip enables, write enable and output enable, which pass through a gate. It also drives a data-bus tristate force, the backup-source connect select, and a sticky shipping-seal flag that keeps the backup cell isolated until the first good power-up. After any loss of the operating window, access stays blocked for a recovery hold-off measured in clock cycles. The hold-off length is derived from the clock rate and a time in milliseconds. It starts over if the supply leaves the window again before it ends.

A general reset `rst_n` restarts the sequencer. It does not change the seal. Only the dedicated `factory_rst` input puts the seal back.

Top module: `pfws_supervisor`

## Requirements
- R1: While `factory_rst` is high, and after it is released, the block shows `status` 0 (sealed), `seal_active` 1, `write_protect` 1, `dq_force_hiz` 1 and `batt_connect` 0. The `status` codes are: 0 sealed, 1 running, 2 guarded, 3 on backup, 4 recovering.
- R2: While sealed, `batt_connect` stays 0 even when `vcc_below_sw` is 1. The state stays sealed until the supply is good, which means `vcc_above_op`=1 and `vcc_below_wp`=0.
- R3: The seal clears when a good supply reaches the sequencer. A change on an input reaches the sequencer after SYNC_STAGES+1 clock edges. Once cleared, the seal stays cleared through `rst_n`, and only `factory_rst` sets it again.
- R4: When a good supply reaches the sequencer in the sealed, guarded or reset-restarted state, it enters recovering. It stays there for exactly RECOVER_CYCLES = CLK_KHZ*RECOVER_MS cycles and then enters running, where `write_protect` and `dq_force_hiz` drop to 0.
- R5: If the supply stops being good during recovering, the state returns to guarded. The next recovery counts the full RECOVER_CYCLES again.
- R6: In running, when `vcc_above_op` falls to 0 or `vcc_below_wp` rises to 1, the state becomes guarded with `write_protect` 1, SYNC_STAGES+1 edges after the input change.
- R7: In every state except running, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1 whatever the host drives, and `dq_force_hiz` is 1. In running these pins copy `host_ce_n`, `host_we_n` and `host_oe_n`.
- R8: Once unsealed, guarded with `vcc_below_sw`=1 moves to on-backup with `batt_connect` 1. When `vcc_below_sw` returns to 0 the state goes back to guarded with `batt_connect` 0.
- R9: Only these transitions occur: sealed to recovering; running to guarded; guarded to on-backup or recovering; on-backup to guarded; recovering to guarded or running.
- R10: A pulse on `rst_n` puts the state into guarded when unsealed (or sealed when sealed) and leaves `seal_active` unchanged. A good supply then gives recovering SYNC_STAGES+1 edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low sequencer reset; leaves the seal alone |
| factory_rst | input | 1 | Synchronous active-high reset that also re-seals the backup cell |
| vcc_above_op | input | 1 | Async flag: supply inside operating window |
| vcc_below_wp | input | 1 | Async flag: supply below write-stop level |
| vcc_below_sw | input | 1 | Async flag: supply below backup switchover level |
| host_ce_n | input | 2 | Host chip enables, upper and lower byte, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 2 | Gated chip enables to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| write_protect | output | 1 | High whenever access is blocked |
| dq_force_hiz | output | 1 | Forces the data drivers to high impedance |
| batt_connect | output | 1 | Selects the backup cell as array source |
| seal_active | output | 1 | Backup cell still isolated since factory |
| status | output | 3 | Sequencer state code |

## Verification
A supply flag change passes SYNC_STAGES synchroniser flops and then the state register. The state and every registered output therefore change on the third edge after the input moves, with the default of two stages. The gated memory controls follow `write_protect` in the same cycle. The bench changes inputs on the falling edge and samples 1 ns after a rising edge. For the failure path and the start of recovery it samples once at the second edge, where the old value must hold, and again at the third. The recovery hold-off is checked one cycle before it ends and on the cycle it ends. A reset pulse is checked on the edge that takes it.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

    typedef enum logic [2:0] {
        ST_SEALED  = 3'd0,
        ST_RUN     = 3'd1,
        ST_GUARD   = 3'd2,
        ST_BACKUP  = 3'd3,
        ST_RECOVER = 3'd4
    } pfws_state_e;

    typedef struct packed {
        pfws_state_e state;
        logic        seal;
        logic        protect;
        logic        batt;
    } pfws_fsm_t;

endpackage

// File: rtl/pfws_sync.sv
module pfws_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb chain_d[s] = async_i;
        end else begin : g_next
            always_comb chain_d[s] = chain_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_d[s];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfws_recovery_timer.sv
module pfws_recovery_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned LAST = CYCLES - 1;
    localparam int          CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = run_i && (cnt_q == CW'(LAST));
        if (!run_i)      cnt_d = '0;
        else if (!done_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST));

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pfws_fsm.sv
module pfws_fsm
    import pfws_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        factory_rst,
    input  logic        ok_s,
    input  logic        low_s,
    input  logic        bat_s,
    input  logic        timer_done,
    output pfws_state_e state_o,
    output logic        seal_o,
    output logic        protect_o,
    output logic        batt_o
);
    pfws_fsm_t fsm_d, fsm_q;
    logic      good;

    always_comb begin
        good  = ok_s && !low_s;
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_SEALED:  if (good) fsm_d.state = ST_RECOVER;
            ST_RUN:     if (!good) fsm_d.state = ST_GUARD;
            ST_GUARD: begin
                if (bat_s && !fsm_q.seal) fsm_d.state = ST_BACKUP;
                else if (good)            fsm_d.state = ST_RECOVER;
            end
            ST_BACKUP:  if (!bat_s) fsm_d.state = ST_GUARD;
            ST_RECOVER: begin
                if (!good)          fsm_d.state = ST_GUARD;
                else if (timer_done) fsm_d.state = ST_RUN;
            end
            default:    fsm_d.state = ST_GUARD;
        endcase
        if (good) fsm_d.seal = 1'b0;
        fsm_d.protect = (fsm_d.state != ST_RUN);
        fsm_d.batt    = (fsm_d.state == ST_BACKUP) && !fsm_d.seal;
    end

    always_ff @(posedge clk) begin
        if (factory_rst) begin
            fsm_q.state   <= ST_SEALED;
            fsm_q.seal    <= 1'b1;
            fsm_q.protect <= 1'b1;
            fsm_q.batt    <= 1'b0;
        end else if (!rst_n) begin
            fsm_q.state   <= fsm_q.seal ? ST_SEALED : ST_GUARD;
            fsm_q.protect <= 1'b1;
            fsm_q.batt    <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o   = fsm_q.state;
    assign seal_o    = fsm_q.seal;
    assign protect_o = fsm_q.protect;
    assign batt_o    = fsm_q.batt;

    // R9
    sealed_exit_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        fsm_q.state == ST_SEALED |=> fsm_q.state inside {ST_SEALED, ST_RECOVER});
    // R9
    run_exit_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        fsm_q.state == ST_RUN |=> fsm_q.state inside {ST_RUN, ST_GUARD});
    // R9
    backup_exit_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        fsm_q.state == ST_BACKUP |=> fsm_q.state inside {ST_BACKUP, ST_GUARD});
    // R9
    guard_exit_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        fsm_q.state == ST_GUARD |=> fsm_q.state inside {ST_GUARD, ST_BACKUP, ST_RECOVER});
    // R6
    fail_exit_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        (fsm_q.state == ST_RUN && (!ok_s || low_s)) |=> fsm_q.state == ST_GUARD);
    // R4
    run_entry_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        $rose(fsm_q.state == ST_RUN) |-> $past(timer_done));
    // R3
    seal_sticky_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        !fsm_q.seal |=> !fsm_q.seal);
endmodule

// File: rtl/pfws_gate.sv
module pfws_gate #(
    parameter int CE_W = 2
) (
    input  logic            protect_i,
    input  logic [CE_W-1:0] host_ce_n,
    input  logic            host_we_n,
    input  logic            host_oe_n,
    output logic [CE_W-1:0] mem_ce_n,
    output logic            mem_we_n,
    output logic            mem_oe_n,
    output logic            hiz_o
);
    always_comb begin
        mem_ce_n = protect_i ? '1   : host_ce_n;
        mem_we_n = protect_i ? 1'b1 : host_we_n;
        mem_oe_n = protect_i ? 1'b1 : host_oe_n;
        hiz_o    = protect_i;
    end
endmodule

// File: rtl/pfws_supervisor.sv
module pfws_supervisor
    import pfws_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 125000,
    parameter int unsigned RECOVER_MS  = 125,
    parameter int          SYNC_STAGES = 2,
    parameter int          CE_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            factory_rst,
    input  logic            vcc_above_op,
    input  logic            vcc_below_wp,
    input  logic            vcc_below_sw,
    input  logic [CE_W-1:0] host_ce_n,
    input  logic            host_we_n,
    input  logic            host_oe_n,
    output logic [CE_W-1:0] mem_ce_n,
    output logic            mem_we_n,
    output logic            mem_oe_n,
    output logic            write_protect,
    output logic            dq_force_hiz,
    output logic            batt_connect,
    output logic            seal_active,
    output logic [2:0]      status
);
    localparam int unsigned RECOVER_CYCLES = CLK_KHZ * RECOVER_MS;
    localparam logic [2:0]  FLAG_SAFE      = 3'b010;

    logic        any_rst_n;
    logic [2:0]  flags_s;
    logic        timer_done;
    pfws_state_e state;

    assign any_rst_n = rst_n && !factory_rst;

    pfws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(FLAG_SAFE)) i_sync (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .async_i ({vcc_below_sw, vcc_below_wp, vcc_above_op}),
        .sync_o  (flags_s)
    );

    pfws_recovery_timer #(.CYCLES(RECOVER_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .run_i  (state == ST_RECOVER),
        .done_o (timer_done)
    );

    pfws_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .factory_rst (factory_rst),
        .ok_s        (flags_s[0]),
        .low_s       (flags_s[1]),
        .bat_s       (flags_s[2]),
        .timer_done  (timer_done),
        .state_o     (state),
        .seal_o      (seal_active),
        .protect_o   (write_protect),
        .batt_o      (batt_connect)
    );

    pfws_gate #(.CE_W(CE_W)) i_gate (
        .protect_i (write_protect),
        .host_ce_n (host_ce_n),
        .host_we_n (host_we_n),
        .host_oe_n (host_oe_n),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .hiz_o     (dq_force_hiz)
    );

    assign status = state;

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        (state != ST_RUN) |-> (&mem_ce_n && mem_we_n && mem_oe_n && dq_force_hiz));
    // R2
    sealed_no_batt_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        seal_active |-> !batt_connect);
    // R8
    batt_state_chk: assert property (@(posedge clk) disable iff (factory_rst || !rst_n)
        batt_connect |-> state == ST_BACKUP);
endmodule

// File: tb/test_pfws_supervisor.sv
module test_pfws_supervisor;
    localparam int N = 200;   // 2 kHz-equivalent count * 100 ms

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, factory_rst = 1'b1;
    logic       ok = 1'b0, low = 1'b1, bat = 1'b0;
    logic [1:0] hce = 2'b00;
    logic       hwe = 1'b0, hoe = 1'b0;
    logic [1:0] mce;
    logic       mwe, moe, wp, hiz, batt, seal;
    logic [2:0] status;
    int         n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    pfws_supervisor #(.CLK_KHZ(2), .RECOVER_MS(100)) i_pfws_supervisor (
        .clk(clk), .rst_n(rst_n), .factory_rst(factory_rst),
        .vcc_above_op(ok), .vcc_below_wp(low), .vcc_below_sw(bat),
        .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
        .mem_ce_n(mce), .mem_we_n(mwe), .mem_oe_n(moe),
        .write_protect(wp), .dq_force_hiz(hiz), .batt_connect(batt),
        .seal_active(seal), .status(status)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic supply(logic o, logic l, logic b);
        @(negedge clk);
        ok = o; low = l; bat = b;
    endtask

    task automatic edges(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        factory_rst = 1'b1; rst_n = 1'b0;
        edges(3);
        @(negedge clk); factory_rst = 1'b0; rst_n = 1'b1;
        edges(1);
        check("R1 status", status, 0);
        check("R1 seal", seal, 1);
        check("R1 protect", wp, 1);
        check("R1 hiz", hiz, 1);
        check("R1 batt", batt, 0);
    endtask

    task automatic t_sealed_backup();
        supply(0, 1, 1);
        edges(6);
        check("R2 status", status, 0);
        check("R2 batt", batt, 0);
        check("R7 ce held", mce, 2'b11);
        check("R7 we held", mwe, 1);
    endtask

    task automatic t_first_power();
        supply(0, 1, 0);
        edges(4);
        supply(1, 0, 0);
        edges(2);
        check("R3 seal before latency", seal, 1);
        edges(1);
        check("R3 seal cleared", seal, 0);
        check("R4 recovering", status, 4);
        edges(N - 1);
        check("R4 still recovering", status, 4);
        check("R4 still protected", wp, 1);
        edges(1);
        check("R4 running", status, 1);
        check("R4 protect off", wp, 0);
        check("R7 hiz off", hiz, 0);
        @(negedge clk); hce = 2'b10; hwe = 1'b0; hoe = 1'b1;
        #1;
        check("R7 ce pass", mce, 2'b10);
        check("R7 we pass", mwe, 0);
        check("R7 oe pass", moe, 1);
    endtask

    task automatic t_fail_ok();
        supply(0, 0, 0);
        edges(2);
        check("R6 not yet", status, 1);
        edges(1);
        check("R6 guarded", status, 2);
        check("R6 protect", wp, 1);
        check("R7 we blocked", mwe, 1);
        check("R7 ce blocked", mce, 2'b11);
    endtask

    task automatic t_restart();
        supply(1, 0, 0);
        edges(3);
        check("R5 recovering", status, 4);
        edges(50);
        supply(0, 1, 0);
        edges(3);
        check("R5 R9 abort to guard", status, 2);
        supply(1, 0, 0);
        edges(3);
        check("R5 recount start", status, 4);
        edges(N - 1);
        check("R5 full recount", status, 4);
        edges(1);
        check("R5 running", status, 1);
    endtask

    task automatic t_below_wp();
        supply(1, 1, 0);
        edges(3);
        check("R6 wp flag guard", status, 2);
        edges(5);
        check("R6 stays guarded", status, 2);
    endtask

    task automatic t_switchover();
        supply(0, 1, 1);
        edges(3);
        check("R8 on backup", status, 3);
        check("R8 batt on", batt, 1);
        supply(0, 1, 0);
        edges(3);
        check("R8 back to guard", status, 2);
        check("R8 batt off", batt, 0);
        supply(1, 0, 0);
        edges(3);
        check("R8 R9 recover from guard", status, 4);
    endtask

    task automatic t_rst_pulse();
        @(negedge clk); rst_n = 1'b0;
        edges(1);
        check("R10 guard after reset", status, 2);
        check("R10 seal kept", seal, 0);
        @(negedge clk); rst_n = 1'b1;
        edges(2);
        check("R10 not yet", status, 2);
        edges(1);
        check("R10 recovering", status, 4);
        @(negedge clk); factory_rst = 1'b1;
        edges(1);
        check("R3 reseal", seal, 1);
        check("R3 sealed state", status, 0);
        @(negedge clk); factory_rst = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        edges(1);
        check("R10 sealed stays sealed", status, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_sealed_backup();
        t_first_power();
        t_fail_ok();
        t_restart();
        t_below_wp();
        t_switchover();
        t_rst_pulse();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule